// File: doc/BRIEF.md
# Serial Flash Status-Register Write Sequencer

This block is a host-side controller that writes one byte into the first status register of a serial flash device and then waits for the device's internal write cycle to finish. A single start pulse carries the value to write, a register selector and a two-bit capability field. The capability field says which unlock opcode the attached part accepts. The block then drives a byte-level command port. Each byte on that port is requested with a one-cycle go pulse and completed by an acknowledge that returns the received byte and an error flag. Chip select frames every command. The serializer behind the port lives outside this block.

One attempt has three stages. It first sends a one-byte unlock frame. It then sends the write-status frame, which is the command byte followed by the data byte. Finally it polls the busy bit. Polling starts after a fixed settling wait and then repeats on a fixed step until an overall millisecond budget is used up. All time is counted from a 1 ms tick input, so a simulation can scale it freely. If the part accepts both unlock styles and the first attempt fails, the whole attempt is repeated once with the alternative unlock opcode. The result is given as a done pulse plus held ok and timeout flags.

Top module: `sfw_seq`

## Requirements
- R1: The unlock frame is exactly one byte. It is 0x06 when modeSel[0] (write-enable capable) is set. It is 0x50 when only modeSel[1] (status-enable capable) is set.
- R2: When modeSel is 2'b00 (no capability advertised), the unlock opcode is 0x50.
- R3: When modeSel is 2'b11, the first attempt unlocks with 0x06. A second attempt, unlocking with 0x50, follows only if the first attempt failed. A successful first attempt ends the request.
- R4: The write frame is exactly two bytes: 0x01 and then the requested value.
- R5: After the write frame, at least INIT_MS (100) ticks pass before the first poll frame starts.
- R6: Each poll frame is three bytes: the opcode 0x05 and then two received bytes. Only bit 0 of the first received byte is examined, and the second received byte has no effect. The request succeeds (ok=1) when that bit is 0.
- R7: Poll frames are spaced STEP_MS (10) ticks apart. The budget is BUDGET_MS (5000) ticks including the settling wait, which allows 490 polls per attempt. If the busy bit is still set when the budget is spent, the attempt fails with timedOut=1 and ok=0.
- R8: A request whose regSel is not 0 gets a done pulse with ok=0 and timedOut=0, and chip select never rises.
- R9: An error flagged on an acknowledge aborts the current attempt at once, with no further bytes and no polling.
- R10: Chip select drops between any two frames, and at most one byte request is outstanding at any time.
- R11: done is a one-cycle pulse. ok and timedOut hold their values until the next accepted start. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request pulse, taken while idle |
| wrValue | input | 8 | Byte to write into the status register |
| regSel | input | 2 | Target register, 0 = first status register |
| modeSel | input | 2 | bit0 write-enable unlock supported, bit1 status-enable unlock supported |
| msTick | input | 1 | Millisecond time base pulse |
| spiSel | output | 1 | Chip select, high for the duration of a frame |
| spiGo | output | 1 | One-cycle request to shift one byte |
| spiTx | output | 8 | Byte to send with spiGo |
| spiAck | input | 1 | Byte complete |
| spiRx | input | 8 | Byte received, valid with spiAck |
| spiErr | input | 1 | Command port error, valid with spiAck |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last request succeeded |
| timedOut | output | 1 | Last attempt ended with the busy bit still set |

## Verification
A rejected request raises done one clock after the start edge. An accepted one raises done one clock after the acknowledge of the last poll byte or of the aborting byte, and ok and timedOut are valid on that same clock. The bench therefore samples on falling edges, waits for done, and reads the flags in that same half-period. It reads them again a few cycles later to confirm they are held. Timing is checked from the command-port model's log of frame start and end cycles, with the tick held high every cycle. The settling gap must be 101–104 cycles and each poll gap 11–14 cycles. These windows include the one-cycle state hops around each wait.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_SR_ENABLE = 8'h50;
  localparam logic [7:0] OP_SR_WRITE  = 8'h01;
  localparam logic [7:0] OP_SR_READ   = 8'h05;
  localparam logic [1:0] REG_PRIMARY  = 2'd0;

  typedef enum logic [2:0] {
    TX_NONE, TX_ENABLE, TX_WRITE_OP, TX_DATA, TX_READ_OP
  } txSel_e;

  typedef struct packed {
    logic   capReq;
    logic   altOp;
    logic   loadInit;
    logic   loadStep;
    logic   stepDec;
    logic   capStatus;
    txSel_e txSel;
  } dpCtl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_EN_BYTE, S_GAP_A, S_WR_OP, S_WR_DATA, S_GAP_B, S_INIT_WAIT,
    S_RD_OP, S_RD_IN0, S_RD_IN1, S_EVAL, S_STEP_WAIT, S_ATT_FAIL
  } seqState_e;

endpackage

// File: rtl/sfw_datapath.sv
module sfw_datapath
  import sfw_pkg::*;
#(
  parameter int INIT_MS   = 100,
  parameter int STEP_MS   = 10,
  parameter int BUDGET_MS = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [7:0] wrValue,
  input  logic [1:0] modeSel,
  input  logic       msTick,
  input  logic [7:0] spiRx,
  output logic [7:0] txByte,
  output logic       waitDone,
  output logic       budgetLast,
  output logic       wipBit,
  output logic       retryOk
);

  localparam int CNT_W     = $clog2(BUDGET_MS + 1);
  localparam int AFTER_INIT = (BUDGET_MS > INIT_MS) ? BUDGET_MS - INIT_MS : 0;

  logic [7:0]       dataR;
  logic [7:0]       statusR;
  logic             weCap;
  logic             ewCap;
  logic             useAlt;
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] remMs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataR  <= '0;
      weCap  <= 1'b0;
      ewCap  <= 1'b0;
      useAlt <= 1'b0;
    end else if (ctl.capReq) begin
      dataR  <= wrValue;
      weCap  <= modeSel[0];
      ewCap  <= modeSel[1] | ~modeSel[0];
      useAlt <= ~modeSel[0];
    end else if (ctl.altOp) begin
      useAlt <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      waitCnt <= '0;
    else if (ctl.loadInit)
      waitCnt <= CNT_W'(INIT_MS);
    else if (ctl.loadStep)
      waitCnt <= CNT_W'(STEP_MS);
    else if (msTick && waitCnt != '0)
      waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      remMs <= '0;
    else if (ctl.loadInit)
      remMs <= CNT_W'(AFTER_INIT);
    else if (ctl.stepDec)
      remMs <= (remMs > CNT_W'(STEP_MS)) ? remMs - CNT_W'(STEP_MS) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      statusR <= '0;
    else if (ctl.capStatus)
      statusR <= spiRx;
  end

  always_comb begin
    unique case (ctl.txSel)
      TX_ENABLE:   txByte = useAlt ? OP_SR_ENABLE : OP_WR_ENABLE;
      TX_WRITE_OP: txByte = OP_SR_WRITE;
      TX_DATA:     txByte = dataR;
      TX_READ_OP:  txByte = OP_SR_READ;
      default:     txByte = 8'h00;
    endcase
  end

  assign waitDone   = (waitCnt == '0);
  assign budgetLast = (remMs <= CNT_W'(STEP_MS));
  assign wipBit     = statusR[0];
  assign retryOk    = weCap & ewCap & ~useAlt;

  // R5: the wait counter moves only on a tick or a reload
  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadInit && !ctl.loadStep && !msTick) |=> $stable(waitCnt));

  // R7: the remaining budget never grows inside an attempt
  assert_budget_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadInit |=> remMs <= $past(remMs));

endmodule

// File: rtl/sfw_control.sv
module sfw_control
  import sfw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] regSel,
  input  logic       spiAck,
  input  logic       spiErr,
  input  logic       waitDone,
  input  logic       budgetLast,
  input  logic       wipBit,
  input  logic       retryOk,
  output dpCtl_t     ctl,
  output logic       spiGo,
  output logic       spiSel,
  output logic       busy,
  output logic       done,
  output logic       ok,
  output logic       timedOut
);

  seqState_e state, nxt;
  logic      issued;
  logic      tmoFlag;
  logic      byteState;
  logic      ackHit;

  assign byteState = (state == S_EN_BYTE) || (state == S_WR_OP) || (state == S_WR_DATA) ||
                     (state == S_RD_OP) || (state == S_RD_IN0) || (state == S_RD_IN1);
  assign spiSel = byteState;
  assign spiGo  = byteState && !issued;
  assign ackHit = spiAck && issued;
  assign busy   = (state != S_IDLE);

  always_comb begin
    ctl = '0;
    ctl.txSel = TX_NONE;
    nxt = state;
    unique case (state)
      S_IDLE: if (startReq && regSel == REG_PRIMARY) begin
        ctl.capReq = 1'b1;
        nxt = S_EN_BYTE;
      end
      S_EN_BYTE: begin
        ctl.txSel = TX_ENABLE;
        if (ackHit) nxt = spiErr ? S_ATT_FAIL : S_GAP_A;
      end
      S_GAP_A: nxt = S_WR_OP;
      S_WR_OP: begin
        ctl.txSel = TX_WRITE_OP;
        if (ackHit) nxt = spiErr ? S_ATT_FAIL : S_WR_DATA;
      end
      S_WR_DATA: begin
        ctl.txSel = TX_DATA;
        if (ackHit) nxt = spiErr ? S_ATT_FAIL : S_GAP_B;
      end
      S_GAP_B: begin
        ctl.loadInit = 1'b1;
        nxt = S_INIT_WAIT;
      end
      S_INIT_WAIT: if (waitDone) nxt = S_RD_OP;
      S_RD_OP: begin
        ctl.txSel = TX_READ_OP;
        if (ackHit) nxt = spiErr ? S_ATT_FAIL : S_RD_IN0;
      end
      S_RD_IN0: if (ackHit) begin
        ctl.capStatus = 1'b1;
        nxt = spiErr ? S_ATT_FAIL : S_RD_IN1;
      end
      S_RD_IN1: if (ackHit) nxt = spiErr ? S_ATT_FAIL : S_EVAL;
      S_EVAL: begin
        if (!wipBit) nxt = S_IDLE;
        else begin
          ctl.loadStep = 1'b1;
          nxt = S_STEP_WAIT;
        end
      end
      S_STEP_WAIT: if (waitDone) begin
        if (budgetLast) nxt = S_ATT_FAIL;
        else begin
          ctl.stepDec = 1'b1;
          nxt = S_RD_OP;
        end
      end
      S_ATT_FAIL: begin
        if (retryOk) begin
          ctl.altOp = 1'b1;
          nxt = S_EN_BYTE;
        end else nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      issued   <= 1'b0;
      tmoFlag  <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      state <= nxt;
      done  <= 1'b0;
      if (spiGo) issued <= 1'b1;
      else if (spiAck) issued <= 1'b0;
      unique case (state)
        S_IDLE: if (startReq) begin
          ok       <= 1'b0;
          timedOut <= 1'b0;
          tmoFlag  <= 1'b0;
          if (regSel != REG_PRIMARY) done <= 1'b1;
        end
        S_EVAL: if (!wipBit) begin
          done <= 1'b1;
          ok   <= 1'b1;
        end
        S_STEP_WAIT: if (waitDone && budgetLast) tmoFlag <= 1'b1;
        S_ATT_FAIL: begin
          if (retryOk) tmoFlag <= 1'b0;
          else begin
            done     <= 1'b1;
            ok       <= 1'b0;
            timedOut <= tmoFlag;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: a byte request is followed by no new request until acknowledged
  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    spiGo |=> !spiGo);

  // R10: the unlock frame ends with chip select released
  assert_sel_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EN_BYTE && ackHit && !spiErr) |=> !spiSel);

  // R11: completion lasts exactly one cycle
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: success and timeout never reported together
  assert_result_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ok && timedOut));

  // R8: a request for another register finishes at once without a frame
  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && startReq && regSel != REG_PRIMARY) |=> (done && !ok && !spiSel));

  // R9: an error during unlock or write leaves the frame immediately
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_EN_BYTE || state == S_WR_OP || state == S_WR_DATA) && ackHit && spiErr)
      |=> !spiSel);

endmodule

// File: rtl/sfw_seq.sv
module sfw_seq
  import sfw_pkg::*;
#(
  parameter int INIT_MS   = 100,
  parameter int STEP_MS   = 10,
  parameter int BUDGET_MS = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [7:0] wrValue,
  input  logic [1:0] regSel,
  input  logic [1:0] modeSel,
  input  logic       msTick,
  output logic       spiSel,
  output logic       spiGo,
  output logic [7:0] spiTx,
  input  logic       spiAck,
  input  logic [7:0] spiRx,
  input  logic       spiErr,
  output logic       busy,
  output logic       done,
  output logic       ok,
  output logic       timedOut
);

  dpCtl_t ctl;
  logic   waitDone;
  logic   budgetLast;
  logic   wipBit;
  logic   retryOk;

  sfw_control u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .regSel(regSel),
    .spiAck(spiAck), .spiErr(spiErr), .waitDone(waitDone),
    .budgetLast(budgetLast), .wipBit(wipBit), .retryOk(retryOk),
    .ctl(ctl), .spiGo(spiGo), .spiSel(spiSel), .busy(busy),
    .done(done), .ok(ok), .timedOut(timedOut)
  );

  sfw_datapath #(.INIT_MS(INIT_MS), .STEP_MS(STEP_MS), .BUDGET_MS(BUDGET_MS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrValue(wrValue), .modeSel(modeSel),
    .msTick(msTick), .spiRx(spiRx), .txByte(spiTx), .waitDone(waitDone),
    .budgetLast(budgetLast), .wipBit(wipBit), .retryOk(retryOk)
  );

endmodule

// File: tb/tb_sfw_seq.sv
module tb_sfw_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [7:0] wrValue = 8'h00;
  logic [1:0] regSel = 2'd0;
  logic [1:0] modeSel = 2'd0;
  logic       msTick = 1'b1;
  logic       spiSel, spiGo, busy, done, ok, timedOut;
  logic [7:0] spiTx;
  logic       spiAck = 1'b0;
  logic [7:0] spiRx = 8'h00;
  logic       spiErr = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0] frameOp [0:2047];
  logic [7:0] frameB1 [0:2047];
  int         frameLen [0:2047];
  int         frameBeg [0:2047];
  int         frameEnd [0:2047];
  int         nFrames = 0;
  int         curLen = 0;
  logic [7:0] curOp = 8'h00;
  logic [7:0] curB1 = 8'h00;
  int         readsDone = 0;
  int         wipReads = 0;
  logic [7:0] errOp = 8'h00;
  int         errLeft = 0;
  logic       pend = 1'b0;
  logic [7:0] pendRx = 8'h00;
  logic       pendErr = 1'b0;
  logic       prevSel = 1'b0;

  sfw_seq dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wrValue(wrValue),
    .regSel(regSel), .modeSel(modeSel), .msTick(msTick),
    .spiSel(spiSel), .spiGo(spiGo), .spiTx(spiTx), .spiAck(spiAck),
    .spiRx(spiRx), .spiErr(spiErr), .busy(busy), .done(done),
    .ok(ok), .timedOut(timedOut)
  );

  initial forever #2 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  // command port model, driven on falling edges
  initial forever begin
    @(negedge clk);
    spiAck = 1'b0;
    spiErr = 1'b0;
    if (prevSel && !spiSel) begin
      frameOp[nFrames]  = curOp;
      frameB1[nFrames]  = curB1;
      frameLen[nFrames] = curLen;
      frameEnd[nFrames] = cyc;
      nFrames++;
      curLen = 0;
    end
    if (spiSel && !prevSel) frameBeg[nFrames] = cyc;
    if (pend) begin
      spiAck = 1'b1;
      spiRx  = pendRx;
      spiErr = pendErr;
      pend   = 1'b0;
    end else if (spiGo) begin
      pendRx = 8'h00;
      pendErr = 1'b0;
      if (curLen == 0) curOp = spiTx;
      if (curLen == 1) curB1 = spiTx;
      if (curLen == 0 && spiTx == errOp && errLeft > 0) begin
        pendErr = 1'b1;
        errLeft--;
      end
      if (curOp == 8'h05 && curLen == 1) begin
        pendRx = (readsDone < wipReads) ? 8'h01 : 8'h00;
        readsDone++;
      end
      if (curOp == 8'h05 && curLen == 2) pendRx = 8'hFF;
      curLen++;
      pend = 1'b1;
    end
    prevSel = spiSel;
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int countOp(input logic [7:0] op);
    int n = 0;
    for (int i = 0; i < nFrames; i++) if (frameOp[i] == op) n++;
    return n;
  endfunction

  task automatic prepModel(input int wip, input logic [7:0] eop, input int ecount);
    nFrames = 0;
    readsDone = 0;
    wipReads = wip;
    errOp = eop;
    errLeft = ecount;
  endtask

  task automatic runReq(input logic [7:0] v, input logic [1:0] rs, input logic [1:0] ms);
    int guard = 0;
    @(negedge clk);
    wrValue = v; regSel = rs; modeSel = ms; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (!done && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic tReset();
    chk(!done && !ok && !timedOut && !busy && !spiSel, "R11 reset outputs",
        {done, ok, timedOut, busy, spiSel}, 0);
  endtask

  task automatic tWriteEnableOnly();
    prepModel(3, 8'h00, 0);
    wrValue = 8'h00;
    fork
      runReq(8'hA5, 2'd0, 2'b01);
    join
    chk(ok == 1'b1 && timedOut == 1'b0, "R6 success after busy clears", {ok, timedOut}, 2);
    chk(nFrames == 6, "R4 frame count", nFrames, 6);
    chk(frameOp[0] == 8'h06 && frameLen[0] == 1, "R1 unlock byte 0x06", frameOp[0], 8'h06);
    chk(frameOp[1] == 8'h01 && frameLen[1] == 2 && frameB1[1] == 8'hA5, "R4 write frame",
        frameB1[1], 8'hA5);
    chk(countOp(8'h05) == 4 && frameLen[2] == 3, "R6 poll frames", countOp(8'h05), 4);
    chk(frameBeg[2] - frameEnd[1] >= 101 && frameBeg[2] - frameEnd[1] <= 104,
        "R5 settling gap", frameBeg[2] - frameEnd[1], 102);
    chk(frameBeg[3] - frameEnd[2] >= 11 && frameBeg[3] - frameEnd[2] <= 14,
        "R7 poll spacing", frameBeg[3] - frameEnd[2], 12);
    chk(frameBeg[1] > frameEnd[0], "R10 select drops between frames", frameBeg[1], frameEnd[0]);
    repeat (3) @(negedge clk);
    chk(ok == 1'b1 && done == 1'b0, "R11 result held, done pulse", {ok, done}, 2);
  endtask

  task automatic tNoCapability();
    prepModel(0, 8'h00, 0);
    runReq(8'h3C, 2'd0, 2'b00);
    chk(frameOp[0] == 8'h50 && nFrames == 3 && ok, "R2 default unlock 0x50", frameOp[0], 8'h50);
  endtask

  task automatic tStatusEnableOnly();
    prepModel(0, 8'h00, 0);
    runReq(8'h80, 2'd0, 2'b10);
    chk(frameOp[0] == 8'h50 && frameLen[0] == 1 && ok, "R1 unlock byte 0x50", frameOp[0], 8'h50);
  endtask

  task automatic tBothSuccess();
    prepModel(1, 8'h00, 0);
    runReq(8'h1C, 2'd0, 2'b11);
    chk(frameOp[0] == 8'h06 && countOp(8'h50) == 0 && ok, "R3 no retry after success",
        countOp(8'h50), 0);
  endtask

  task automatic tBothRetryOnError();
    prepModel(0, 8'h06, 1);
    runReq(8'h42, 2'd0, 2'b11);
    chk(nFrames == 4 && frameOp[1] == 8'h50, "R3 retry with 0x50", frameOp[1], 8'h50);
    chk(ok == 1'b1, "R9 error on unlock aborts then retry succeeds", ok, 1);
  endtask

  task automatic tWriteErrorNoRetry();
    prepModel(0, 8'h01, 1);
    runReq(8'h42, 2'd0, 2'b01);
    chk(nFrames == 2 && frameLen[1] == 1 && countOp(8'h05) == 0, "R9 no poll after abort",
        nFrames, 2);
    chk(!ok && !timedOut, "R9 failure flags", {ok, timedOut}, 0);
  endtask

  task automatic tReject();
    prepModel(0, 8'h00, 0);
    runReq(8'h55, 2'd2, 2'b01);
    chk(nFrames == 0 && !ok && !timedOut, "R8 rejected without traffic", nFrames, 0);
  endtask

  task automatic tTimeout();
    prepModel(100000, 8'h00, 0);
    runReq(8'h9C, 2'd0, 2'b11);
    chk(timedOut && !ok, "R7 timeout flag", {ok, timedOut}, 1);
    chk(countOp(8'h05) == 980, "R7 490 polls per attempt", countOp(8'h05), 980);
    chk(nFrames == 984 && frameOp[492] == 8'h50, "R3 second attempt after timeout",
        frameOp[492], 8'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tWriteEnableOnly();
    tNoCapability();
    tStatusEnableOnly();
    tBothSuccess();
    tBothRetryOnError();
    tWriteErrorNoRetry();
    tReject();
    tTimeout();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule